// File: doc/BRIEF.md
# Settable Minutes-Seconds Countdown Timer

This block keeps a countdown value of up to 99 minutes 59 seconds as four BCD digits, two for minutes and two for seconds. The digits go out in parallel to a multiplexed seven-segment driver, which is outside the block. A mode input picks between adjusting and running. While adjusting, single-cycle up and down pulses from debounced buttons step the value by one second, with carries and borrows between the digits.

While running, an internal divider of the system clock produces one step per second. Each step lowers the value by one second. A run level input freezes both the count and the divider phase while it is low. When the value reaches zero the count stops and an alarm output is raised. The alarm stays high until the mode returns to adjusting or reset is applied.

The divider period is a parameter. On the target it is the clock frequency in hertz, and a test can set it to a few cycles.

Top module: `mmss_countdown`

## Requirements
- R1: While rst_ni is low, digits_o reads 16'h0000 and alarm_o reads 0.
- R2: digits_o holds minutes-tens in [15:12], minutes-ones in [11:8], seconds-tens in [7:4] and seconds-ones in [3:0]. With mode_go_i low, a cycle with inc_i high and dec_i low adds one second at the next edge. Seconds-ones carries past 9, seconds-tens carries past 5, and minutes-ones carries past 9.
- R3: With mode_go_i low, a cycle with dec_i high and inc_i low removes one second at the next edge. A zero seconds-ones digit borrows and becomes 9, and a zero seconds-tens digit borrows and becomes 5.
- R4: With mode_go_i low, incrementing 99:59 gives 00:00 and decrementing 00:00 gives 99:59.
- R5: With mode_go_i low, a cycle with inc_i and dec_i both high, or both low, leaves the value unchanged.
- R6: With mode_go_i high, inc_i and dec_i have no effect.
- R7: With mode_go_i and run_i high, the value drops by one second on every TICK_CYCLES-th enabled cycle, counted from entry into GO mode. The first drop comes at the TICK_CYCLES-th edge after entry. From mm:00 with mm nonzero, the next value is (mm-1):59.
- R8: With mode_go_i high and run_i low, the value stays constant. The divider phase is kept, so the next drop comes after the cycles that remained before the pause.
- R9: In GO mode the value never goes below 00:00. It stays at 00:00.
- R10: alarm_o goes high at the edge where the value becomes, or stands at, 00:00 with mode_go_i high. It stays high while mode_go_i stays high, and falls at the first edge with mode_go_i low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_go_i | input | 1 | 1 = GO (count down), 0 = SET (adjust) |
| run_i | input | 1 | Run level in GO mode; low pauses |
| inc_i | input | 1 | One-cycle up pulse, SET mode |
| dec_i | input | 1 | One-cycle down pulse, SET mode |
| digits_o | output | 16 | Four BCD digits, mm:ss |
| alarm_o | output | 1 | High once the countdown has reached zero |

## Verification
Two situations are hard to reach from the ports. One is the borrow from a zero seconds field while the clock is running. The other is a pause that falls in the middle of a divider period. The bench first uses button pulses to load 01:02. It then counts edges from the moment GO mode starts, drops run_i partway through a divider period, and checks that the remaining fraction of that period is kept when counting resumes. It then follows the count down through 01:00 to 00:59 and on to zero, and checks when the alarm rises and when it falls.

// File: rtl/mmss_pkg.sv
package mmss_pkg;
  localparam int DIGITS = 4;
  localparam int BCD_W  = 4;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef bcd_t [DIGITS-1:0] mmss_t;  // [0]=sec ones .. [3]=min tens

  // seconds-tens rolls at 5, all others at 9
  function automatic int digit_max(int idx);
    return (idx == 1) ? 5 : 9;
  endfunction
endpackage

// File: rtl/mmss_tick_gen.sv
module mmss_tick_gen #(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (en_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/mmss_digit_step.sv
module mmss_digit_step
  import mmss_pkg::*;
#(
  parameter int MAX = 9
) (
  input  bcd_t d_i,
  input  logic en_i,
  input  logic up_i,
  output bcd_t d_o,
  output logic carry_o
);
  localparam bcd_t LIMIT = bcd_t'(MAX);

  always_comb begin
    d_o     = d_i;
    carry_o = 1'b0;
    if (en_i) begin
      if (up_i) begin
        if (d_i == LIMIT) begin
          d_o     = '0;
          carry_o = 1'b1;
        end else begin
          d_o = d_i + 1'b1;
        end
      end else begin
        if (d_i == '0) begin
          d_o     = LIMIT;
          carry_o = 1'b1;
        end else begin
          d_o = d_i - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mmss_countdown.sv
module mmss_countdown
  import mmss_pkg::*;
#(
  parameter int TICK_CYCLES = 50_000_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mode_go_i,
  input  logic                    run_i,
  input  logic                    inc_i,
  input  logic                    dec_i,
  output logic [DIGITS*BCD_W-1:0] digits_o,
  output logic                    alarm_o
);
  mmss_t       time_q, time_nxt, time_d;
  logic [DIGITS:0] carry;
  logic        tick, step_en, dir_up, commit;
  logic        alarm_q;

  mmss_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!mode_go_i),
    .en_i   (mode_go_i && run_i),
    .tick_o (tick)
  );

  assign step_en  = mode_go_i ? tick : (inc_i ^ dec_i);
  assign dir_up   = !mode_go_i && inc_i;
  assign carry[0] = step_en;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    mmss_digit_step #(.MAX(digit_max(g))) u_dig (
      .d_i    (time_q[g]),
      .en_i   (carry[g]),
      .up_i   (dir_up),
      .d_o    (time_nxt[g]),
      .carry_o(carry[g+1])
    );
  end

  // borrow out of the top digit in GO means the value was 00:00
  assign commit = step_en && !(mode_go_i && carry[DIGITS]);
  assign time_d = commit ? time_nxt : time_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      time_q  <= time_d;
      alarm_q <= mode_go_i && (time_d == '0);
    end
  end

  assign digits_o = time_q;
  assign alarm_o  = alarm_q;
endmodule

// File: rtl/mmss_countdown_chk.sv
module mmss_countdown_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mode_go_i,
  input logic        run_i,
  input logic        inc_i,
  input logic        dec_i,
  input logic [15:0] digits_o,
  input logic        alarm_o
);
  p_bcd_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[3:0] <= 4'd9) && (digits_o[7:4] <= 4'd5) &&
    (digits_o[11:8] <= 4'd9) && (digits_o[15:12] <= 4'd9));

  p_set_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_go_i && (inc_i == dec_i)) |=> $stable(digits_o));

  p_pause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_go_i && !run_i) |=> $stable(digits_o));

  p_floor_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_go_i && digits_o == 16'h0000) |=> (digits_o == 16'h0000));

  p_alarm_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> (digits_o == 16'h0000));

  p_alarm_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_go_i |=> !alarm_o);
endmodule

bind mmss_countdown mmss_countdown_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_go_i(mode_go_i),
  .run_i    (run_i),
  .inc_i    (inc_i),
  .dec_i    (dec_i),
  .digits_o (digits_o),
  .alarm_o  (alarm_o)
);

// File: tb/mmss_countdown_tb.sv
`timescale 1ns/1ps
module mmss_countdown_tb;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0, run = 1'b0, inc = 1'b0, dec = 1'b0;
  logic [15:0] digits;
  logic        alarm;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mmss_countdown #(.TICK_CYCLES(TICK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_go_i(go), .run_i(run),
    .inc_i(inc), .dec_i(dec), .digits_o(digits), .alarm_o(alarm)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 none, 1 inc, 2 dec, 3 both
    logic [9:0]  reps;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // SET-mode walk from 00:00 (R2 carry, R3 borrow, R4 wrap, R5 no-op)
  localparam vec_t VEC [14] = '{
    '{2'd2, 10'd1,   16'h9959, 4'd4},
    '{2'd1, 10'd1,   16'h0000, 4'd4},
    '{2'd1, 10'd9,   16'h0009, 4'd2},
    '{2'd1, 10'd1,   16'h0010, 4'd2},
    '{2'd1, 10'd49,  16'h0059, 4'd2},
    '{2'd1, 10'd1,   16'h0100, 4'd2},
    '{2'd2, 10'd1,   16'h0059, 4'd3},
    '{2'd2, 10'd50,  16'h0009, 4'd3},
    '{2'd3, 10'd3,   16'h0009, 4'd5},
    '{2'd0, 10'd3,   16'h0009, 4'd5},
    '{2'd1, 10'd51,  16'h0100, 4'd2},
    '{2'd1, 10'd539, 16'h0959, 4'd2},
    '{2'd1, 10'd1,   16'h1000, 4'd2},
    '{2'd2, 10'd1,   16'h0959, 4'd3}
  };

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] exp_d, logic exp_a);
    checks++;
    if (digits !== exp_d || alarm !== exp_a) begin
      errors++;
      $display("FAIL %s digits=%h alarm=%b expected digits=%h alarm=%b",
               req, digits, alarm, exp_d, exp_a);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(2);
    chk("R1", 16'h0000, 1'b0);
    rst_n = 1'b1;
    step(1);
    for (int i = 0; i < 14; i++) begin
      inc = VEC[i].op[0];
      dec = VEC[i].op[1];
      step(int'(VEC[i].reps));
      inc = 1'b0; dec = 1'b0;
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp, 1'b0);
    end

    // R1: async reset mid-value
    rst_n = 1'b0;
    #1;
    chk("R1", 16'h0000, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(1);

    // load 01:02
    inc = 1'b1; step(62); inc = 1'b0;
    chk("R2", 16'h0102, 1'b0);

    // R7: first drop at the TICK-th edge after entering GO
    go = 1'b1; run = 1'b1;
    step(TICK - 1);
    chk("R7", 16'h0102, 1'b0);
    step(1);
    chk("R7", 16'h0101, 1'b0);

    // R6: button ignored in GO
    inc = 1'b1; step(1); inc = 1'b0;
    chk("R6", 16'h0101, 1'b0);
    dec = 1'b1; step(1); dec = 1'b0;
    chk("R6", 16'h0101, 1'b0);

    // R8: pause mid-period, phase kept (two enabled edges used)
    run = 1'b0;
    step(10);
    chk("R8", 16'h0101, 1'b0);
    run = 1'b1;
    step(TICK - 3);
    chk("R8", 16'h0101, 1'b0);
    step(1);
    chk("R8", 16'h0100, 1'b0);

    // R7: borrow at mm:00
    step(TICK);
    chk("R7", 16'h0059, 1'b0);

    // R10: alarm rises with 00:00
    step(59 * TICK - 1);
    chk("R10", 16'h0001, 1'b0);
    step(1);
    chk("R10", 16'h0000, 1'b1);

    // R9: stays at zero, alarm held
    step(5 * TICK);
    chk("R9", 16'h0000, 1'b1);

    // R10: leaving GO clears alarm
    go = 1'b0;
    step(1);
    chk("R10", 16'h0000, 1'b0);

    // R10: entering GO already at zero raises alarm after one edge
    go = 1'b1;
    step(1);
    chk("R10", 16'h0000, 1'b1);
    go = 1'b0;
    step(1);
    chk("R10", 16'h0000, 1'b0);

    summary();
  end
endmodule